// File: doc/BRIEF.md
# Prefixed Opcode Escape Decoder

This block sits behind an instruction byte fetcher and turns a stream of opcode bytes, delivered one per accepted valid/ready transfer, into whole decoded instructions. It tracks the index-register prefixes and the extended prefix. A plain opcode leaves the block on the instruction port together with a two-bit tag that records which prefix came before it.

One byte pair, the extended prefix followed by an otherwise unused second byte, is treated as an escape into a coprocessor command set. The byte after the pair is a command code. Depending on that code the block either finishes at once or takes one more operand byte, and the result leaves on a separate command port. The command port never shares a pulse with the instruction port. An unrecognised command code raises a one-cycle illegal flag and sends the decoder back to idle.

Every finished instruction leaves as a single-cycle pulse. While that pulse is out, the input side is not ready. After it, the prefix state is cleared, so the next byte begins a fresh instruction.

Top module: `op_prefix_decoder`

## Requirements
- R1: A synchronous, active-high `rst` puts the decoder in idle with the prefix tag cleared. On the first cycle after reset, `inReady` is 1 and `insValid`, `cmdValid` and `cmdIllegal` are all 0.
- R2: In idle, a byte other than 0xDD, 0xFD or 0xED is a complete instruction. It is emitted with `insOpcode` equal to that byte and `insTag` = 2'b00.
- R3: After 0xDD the next accepted byte, whatever its value, is emitted as the opcode with `insTag` = 2'b01. After 0xFD the tag is 2'b10 instead.
- R4: After 0xED, any byte other than 0xFF is emitted as an opcode with `insTag` = 2'b11.
- R5: The sequence 0xED 0xFF never produces `insValid`. Its result appears only on the command port.
- R6: Command code 0x01 after 0xED 0xFF finishes at once and consumes no operand byte. It emits `cmdValid` with `cmdCode` = 0x01, `cmdRegArg` = 1, `cmdHasOperand` = 0 and `cmdOperand` = 0.
- R7: Command code 0x03 after 0xED 0xFF consumes exactly one further byte. It then emits `cmdValid` with `cmdCode` = 0x03, `cmdRegArg` = 0, `cmdHasOperand` = 1 and `cmdOperand` equal to that byte.
- R8: Any other command code after 0xED 0xFF gives a one-cycle `cmdIllegal` pulse with `cmdCode` equal to the offending code and no `cmdValid`. The decoder then returns to idle.
- R9: Each result pulse lasts exactly one cycle, in the cycle after the final byte is accepted. At most one of `insValid`, `cmdValid` and `cmdIllegal` is high at a time. `inReady` is 0 during that cycle and 1 in every other cycle out of reset.
- R10: After each emitted result the prefix state is empty, so a following plain opcode carries tag 2'b00.
- R11: A cycle with `inValid` low consumes nothing. The partially decoded prefix state is kept across such gaps, and no result is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Input byte is valid |
| inByte | input | DATA_W | Opcode stream byte |
| inReady | output | 1 | Decoder accepts a byte this cycle |
| insValid | output | 1 | One-cycle pulse: normal instruction out |
| insOpcode | output | DATA_W | Final opcode byte of the instruction |
| insTag | output | 2 | Prefix tag: 00 none, 01 first index, 10 second index, 11 extended |
| cmdValid | output | 1 | One-cycle pulse: coprocessor command out |
| cmdIllegal | output | 1 | One-cycle pulse: unknown command code |
| cmdCode | output | DATA_W | Command code byte |
| cmdRegArg | output | 1 | Command takes its argument from a register |
| cmdHasOperand | output | 1 | Command carried an operand byte |
| cmdOperand | output | DATA_W | Operand byte, zero when there is none |

## Verification
The bench builds the decoder with its default parameters: an 8-bit byte, the prefix values 0xDD, 0xFD and 0xED, the escape second byte 0xFF, and the command codes 0x01 and 0x03. Because these are only a handful of the 256 byte values, the random stream is weighted toward them. This way back-to-back prefixes, an escape cut off by the unused byte, and unknown command codes all come up often, next to fully random opcode and operand bytes. Random idle gaps and an input held valid through the output cycle exercise the handshake. A reset in the middle of a prefix checks that partial state is dropped.

// File: rtl/opdec_pkg.sv
package opdec_pkg;

  typedef enum logic [1:0] {
    TAG_NONE = 2'b00,
    TAG_IX   = 2'b01,
    TAG_IY   = 2'b10,
    TAG_EXT  = 2'b11
  } tag_t;

  typedef enum logic [1:0] {
    OUT_INS,
    OUT_CMD,
    OUT_BAD
  } outKind_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_IDX,
    ST_EXT,
    ST_ESC,
    ST_ARG,
    ST_EMIT
  } state_t;

  // strobes from control to datapath
  typedef struct packed {
    logic ldOpcode;
    logic ldCode;
    logic ldOperand;
    logic clrOperand;
    logic ldFlags;
    logic regArg;
    logic hasOp;
    logic setTag;
    tag_t tagVal;
    logic clrTag;
  } strobe_t;

endpackage

// File: rtl/opdec_datapath.sv
module opdec_datapath
  import opdec_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] inByte,
  input  strobe_t           stb,
  output logic [DATA_W-1:0] opcodeQ,
  output logic [DATA_W-1:0] codeQ,
  output logic [DATA_W-1:0] operandQ,
  output tag_t              tagQ,
  output logic              regArgQ,
  output logic              hasOpQ
);

  always_ff @(posedge clk) begin
    if (rst) begin
      opcodeQ  <= '0;
      codeQ    <= '0;
      operandQ <= '0;
      tagQ     <= TAG_NONE;
      regArgQ  <= 1'b0;
      hasOpQ   <= 1'b0;
    end else begin
      if (stb.ldOpcode) opcodeQ <= inByte;
      if (stb.ldCode) codeQ <= inByte;
      if (stb.ldOperand) operandQ <= inByte;
      else if (stb.clrOperand) operandQ <= '0;
      if (stb.ldFlags) begin
        regArgQ <= stb.regArg;
        hasOpQ  <= stb.hasOp;
      end
      if (stb.setTag) tagQ <= stb.tagVal;
      else if (stb.clrTag) tagQ <= TAG_NONE;
    end
  end

  // R10: a cleared tag stays cleared until a prefix sets it again
  a_r10_tag_cleared: assert property (@(posedge clk) disable iff (rst)
    (stb.clrTag && !stb.setTag) |=> (tagQ == TAG_NONE));

endmodule

// File: rtl/opdec_ctrl.sv
module opdec_ctrl
  import opdec_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] PFX_IX  = 8'hDD,
  parameter logic [DATA_W-1:0] PFX_IY  = 8'hFD,
  parameter logic [DATA_W-1:0] PFX_EXT = 8'hED,
  parameter logic [DATA_W-1:0] ESC_SEL = 8'hFF,
  parameter logic [DATA_W-1:0] CMD_ROT = 8'h01,
  parameter logic [DATA_W-1:0] CMD_HAD = 8'h03
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [DATA_W-1:0] inByte,
  output logic              inReady,
  output strobe_t           stb,
  output logic              insValid,
  output logic              cmdValid,
  output logic              cmdIllegal
);

  state_t   stateQ, nextState;
  outKind_t kindQ, nextKind;
  logic     accept;

  assign inReady = (stateQ != ST_EMIT);
  assign accept  = inValid && inReady;

  always_comb begin
    nextState = stateQ;
    nextKind  = kindQ;
    stb       = '0;
    unique case (stateQ)
      ST_IDLE: if (accept) begin
        if (inByte == PFX_IX) begin
          stb.setTag = 1'b1;
          stb.tagVal = TAG_IX;
          nextState  = ST_IDX;
        end else if (inByte == PFX_IY) begin
          stb.setTag = 1'b1;
          stb.tagVal = TAG_IY;
          nextState  = ST_IDX;
        end else if (inByte == PFX_EXT) begin
          nextState = ST_EXT;
        end else begin
          stb.ldOpcode = 1'b1;
          nextKind     = OUT_INS;
          nextState    = ST_EMIT;
        end
      end
      ST_IDX: if (accept) begin
        stb.ldOpcode = 1'b1;
        nextKind     = OUT_INS;
        nextState    = ST_EMIT;
      end
      ST_EXT: if (accept) begin
        if (inByte == ESC_SEL) begin
          nextState = ST_ESC;
        end else begin
          stb.ldOpcode = 1'b1;
          stb.setTag   = 1'b1;
          stb.tagVal   = TAG_EXT;
          nextKind     = OUT_INS;
          nextState    = ST_EMIT;
        end
      end
      ST_ESC: if (accept) begin
        stb.ldCode  = 1'b1;
        stb.ldFlags = 1'b1;
        if (inByte == CMD_ROT) begin
          stb.regArg     = 1'b1;
          stb.clrOperand = 1'b1;
          nextKind       = OUT_CMD;
          nextState      = ST_EMIT;
        end else if (inByte == CMD_HAD) begin
          stb.hasOp = 1'b1;
          nextState = ST_ARG;
        end else begin
          stb.clrOperand = 1'b1;
          nextKind       = OUT_BAD;
          nextState      = ST_EMIT;
        end
      end
      ST_ARG: if (accept) begin
        stb.ldOperand = 1'b1;
        nextKind      = OUT_CMD;
        nextState     = ST_EMIT;
      end
      ST_EMIT: begin
        stb.clrTag = 1'b1;
        nextState  = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stateQ <= ST_IDLE;
      kindQ  <= OUT_INS;
    end else begin
      stateQ <= nextState;
      kindQ  <= nextKind;
    end
  end

  assign insValid   = (stateQ == ST_EMIT) && (kindQ == OUT_INS);
  assign cmdValid   = (stateQ == ST_EMIT) && (kindQ == OUT_CMD);
  assign cmdIllegal = (stateQ == ST_EMIT) && (kindQ == OUT_BAD);

  // R1: reset leaves the decoder idle and quiet
  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (inReady && !insValid && !cmdValid && !cmdIllegal));

  // R9: result pulses are exclusive and last one cycle
  a_r9_exclusive: assert property (@(posedge clk) disable iff (rst)
    $onehot0({insValid, cmdValid, cmdIllegal}));
  a_r9_single_pulse: assert property (@(posedge clk) disable iff (rst)
    (insValid || cmdValid || cmdIllegal) |=> !(insValid || cmdValid || cmdIllegal));

  // R5: the byte after an escape pair never yields a normal instruction
  a_r5_escape_diverted: assert property (@(posedge clk) disable iff (rst)
    (stateQ == ST_ESC && accept) |=> !insValid);

  // R6: the rotation code completes without an operand byte
  a_r6_rot_immediate: assert property (@(posedge clk) disable iff (rst)
    (stateQ == ST_ESC && accept && inByte == CMD_ROT) |=> cmdValid);

  // R8: unknown codes flag illegal instead of a command
  a_r8_unknown_code: assert property (@(posedge clk) disable iff (rst)
    (stateQ == ST_ESC && accept && inByte != CMD_ROT && inByte != CMD_HAD)
      |=> (cmdIllegal && !cmdValid));

  // R11: an idle input cycle produces nothing and holds the state
  a_r11_gap_holds: assert property (@(posedge clk) disable iff (rst)
    (!inValid && stateQ != ST_EMIT) |=> ($stable(stateQ) && !insValid && !cmdValid && !cmdIllegal));

endmodule

// File: rtl/op_prefix_decoder.sv
module op_prefix_decoder
  import opdec_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] PFX_IX  = 8'hDD,
  parameter logic [DATA_W-1:0] PFX_IY  = 8'hFD,
  parameter logic [DATA_W-1:0] PFX_EXT = 8'hED,
  parameter logic [DATA_W-1:0] ESC_SEL = 8'hFF,
  parameter logic [DATA_W-1:0] CMD_ROT = 8'h01,
  parameter logic [DATA_W-1:0] CMD_HAD = 8'h03
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [DATA_W-1:0] inByte,
  output logic              inReady,
  output logic              insValid,
  output logic [DATA_W-1:0] insOpcode,
  output logic [1:0]        insTag,
  output logic              cmdValid,
  output logic              cmdIllegal,
  output logic [DATA_W-1:0] cmdCode,
  output logic              cmdRegArg,
  output logic              cmdHasOperand,
  output logic [DATA_W-1:0] cmdOperand
);

  strobe_t stb;
  tag_t    tagQ;

  opdec_ctrl #(
    .DATA_W (DATA_W),
    .PFX_IX (PFX_IX),
    .PFX_IY (PFX_IY),
    .PFX_EXT(PFX_EXT),
    .ESC_SEL(ESC_SEL),
    .CMD_ROT(CMD_ROT),
    .CMD_HAD(CMD_HAD)
  ) uCtrl (
    .clk       (clk),
    .rst       (rst),
    .inValid   (inValid),
    .inByte    (inByte),
    .inReady   (inReady),
    .stb       (stb),
    .insValid  (insValid),
    .cmdValid  (cmdValid),
    .cmdIllegal(cmdIllegal)
  );

  opdec_datapath #(
    .DATA_W(DATA_W)
  ) uData (
    .clk     (clk),
    .rst     (rst),
    .inByte  (inByte),
    .stb     (stb),
    .opcodeQ (insOpcode),
    .codeQ   (cmdCode),
    .operandQ(cmdOperand),
    .tagQ    (tagQ),
    .regArgQ (cmdRegArg),
    .hasOpQ  (cmdHasOperand)
  );

  assign insTag = tagQ;

endmodule

// File: tb/sim_op_prefix_decoder.sv
module sim_op_prefix_decoder;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       inValid = 1'b0;
  logic [7:0] inByte = 8'h00;
  logic       inReady, insValid, cmdValid, cmdIllegal, cmdRegArg, cmdHasOperand;
  logic [7:0] insOpcode, cmdCode, cmdOperand;
  logic [1:0] insTag;

  always #(CLK_PERIOD / 2) clk = ~clk;

  op_prefix_decoder u0 (
    .clk(clk), .rst(rst), .inValid(inValid), .inByte(inByte), .inReady(inReady),
    .insValid(insValid), .insOpcode(insOpcode), .insTag(insTag),
    .cmdValid(cmdValid), .cmdIllegal(cmdIllegal), .cmdCode(cmdCode),
    .cmdRegArg(cmdRegArg), .cmdHasOperand(cmdHasOperand), .cmdOperand(cmdOperand)
  );

  typedef struct packed {
    logic [1:0] kind;    // 0 instruction, 1 command, 2 illegal
    logic [7:0] req;
    logic [7:0] val;     // opcode or command code
    logic [1:0] tag;
    logic       regArg;
    logic       hasOp;
    logic [7:0] opnd;
  } ev_t;

  int  nChecks = 0;
  int  nFails  = 0;
  ev_t expQ[0:63];
  int  wrIdx = 0;
  int  rdIdx = 0;
  int  mSt = 0;
  logic [1:0] mTag = 2'b00;

  task automatic check(input bit ok, input int req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL R%0d %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic push(input logic [1:0] k, input int req, input logic [7:0] v,
                      input logic [1:0] t, input logic ra, input logic ho, input logic [7:0] op);
    ev_t e;
    e.kind = k; e.req = req[7:0]; e.val = v; e.tag = t;
    e.regArg = ra; e.hasOp = ho; e.opnd = op;
    expQ[wrIdx % 64] = e;
    wrIdx++;
    mSt  = 0;      // R10: prefix state empty after every result
    mTag = 2'b00;
  endtask

  // expected behaviour built from the requirements
  task automatic modelByte(input logic [7:0] b);
    case (mSt)
      0: begin
        if (b == 8'hDD) begin mSt = 1; mTag = 2'b01; end
        else if (b == 8'hFD) begin mSt = 1; mTag = 2'b10; end
        else if (b == 8'hED) mSt = 2;
        else push(0, 2, b, 2'b00, 0, 0, 0);                  // R2
      end
      1: push(0, 3, b, mTag, 0, 0, 0);                       // R3
      2: begin
        if (b == 8'hFF) mSt = 3;
        else push(0, 4, b, 2'b11, 0, 0, 0);                  // R4
      end
      3: begin
        if (b == 8'h01) push(1, 6, b, 0, 1, 0, 0);           // R6
        else if (b == 8'h03) mSt = 4;
        else push(2, 8, b, 0, 0, 0, 0);                      // R8
      end
      default: push(1, 7, 8'h03, 0, 0, 1, b);                // R7
    endcase
  endtask

  task automatic monitor();
    logic [1:0] k;
    ev_t e;
    if (rst) return;
    if ($countones({insValid, cmdValid, cmdIllegal}) > 1)
      check(0, 9, "several result pulses", {insValid, cmdValid, cmdIllegal}, 0);
    if (insValid || cmdValid || cmdIllegal) begin
      check(!inReady, 9, "ready during result", inReady, 0);   // R9
      k = insValid ? 2'd0 : (cmdValid ? 2'd1 : 2'd2);
      if (rdIdx == wrIdx) begin
        check(0, 9, "unexpected result kind", k, 3);
      end else begin
        e = expQ[rdIdx % 64];
        rdIdx++;
        // R5: an escape must never show up as an instruction
        check(k == e.kind, (e.kind != 0 && k == 0) ? 5 : int'(e.req), "result kind", k, e.kind);
        if (k == e.kind) begin
          if (k == 0)
            check({insTag, insOpcode} == {e.tag, e.val}, e.req, "tag/opcode",
                  {insTag, insOpcode}, {e.tag, e.val});
          else if (k == 1)
            check({cmdRegArg, cmdHasOperand, cmdCode, cmdOperand} == {e.regArg, e.hasOp, e.val, e.opnd},
                  e.req, "regArg/hasOp/code/operand",
                  {cmdRegArg, cmdHasOperand, cmdCode, cmdOperand}, {e.regArg, e.hasOp, e.val, e.opnd});
          else
            check(cmdCode == e.val, e.req, "illegal code", cmdCode, e.val);
        end
      end
    end else begin
      check(inReady, 9, "ready outside result", inReady, 1);
    end
  endtask

  task automatic step(input bit drive, input logic [7:0] b, output bit took);
    @(negedge clk);
    monitor();
    took = 0;
    if (drive) begin
      inValid = 1'b1;
      inByte  = b;
      if (inReady) begin
        took = 1;
        modelByte(b);
      end
    end else begin
      inValid = 1'b0;
      inByte  = 8'($urandom);
    end
  endtask

  task automatic sendByte(input logic [7:0] b);
    bit t;
    do step(1, b, t); while (!t);
  endtask

  task automatic idle(input int n);
    bit t;
    for (int i = 0; i < n; i++) step(0, 8'h00, t);
  endtask

  task automatic doReset();
    @(negedge clk);
    inValid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    mSt = 0; mTag = 2'b00; rdIdx = wrIdx;
    @(negedge clk);
    // R1: idle and quiet after reset
    check(inReady === 1'b1, 1, "ready after reset", inReady, 1);
    check({insValid, cmdValid, cmdIllegal} === 3'b000, 1, "pulses after reset",
          {insValid, cmdValid, cmdIllegal}, 0);
  endtask

  function automatic logic [7:0] pickByte();
    int r;
    r = int'($urandom % 10);
    case (r)
      0: return 8'hDD;
      1: return 8'hFD;
      2, 3: return 8'hED;
      4: return 8'hFF;
      5: return 8'h01;
      6: return 8'h03;
      default: return 8'($urandom);
    endcase
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    doReset();                                   // R1
    sendByte(8'h2C); idle(2);                    // R2 plain opcode
    sendByte(8'hDD); sendByte(8'h2C); idle(1);   // R3 first index prefix
    sendByte(8'hFD); sendByte(8'h2C); idle(1);   // R3 second index prefix
    sendByte(8'hDD); sendByte(8'hED); idle(1);   // R3 any byte after index prefix
    sendByte(8'hED); sendByte(8'h4A); idle(1);   // R4 extended opcode
    sendByte(8'hED); sendByte(8'hFF); sendByte(8'h01); idle(1);                  // R5 R6
    sendByte(8'hED); sendByte(8'hFF); sendByte(8'h03); sendByte(8'h05); idle(1); // R7
    sendByte(8'hED); sendByte(8'hFF); sendByte(8'h7E); idle(1);                  // R8
    sendByte(8'hDD); sendByte(8'h2C); sendByte(8'h2C); idle(1);                  // R10
    sendByte(8'hED); idle(4); sendByte(8'hFF); idle(3); sendByte(8'h03);
    idle(2); sendByte(8'hA5); idle(1);                                           // R11
    sendByte(8'hDD);
    doReset();                                   // R1 drops the pending prefix
    sendByte(8'h2C); idle(1);
    // back-to-back input held valid through each result cycle (R9)
    sendByte(8'hED); sendByte(8'hFF); sendByte(8'h01); sendByte(8'h3C); sendByte(8'h3C);
    for (int i = 0; i < 3000; i++) begin
      sendByte(pickByte());
      if ($urandom % 4 == 0) idle(1 + int'($urandom % 3));
    end
    // finish any open sequence with plain bytes so every result is seen
    for (int i = 0; i < 4; i++) sendByte(8'h00);
    idle(3);
    check(rdIdx == wrIdx, 9, "results left unseen", wrIdx - rdIdx, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule